// File: doc/BRIEF.md
# Receive Frame Length Classifier and Filter

This block sits at the end of an Ethernet receive path and makes one decision per frame: forward it to memory or drop it. When the upstream byte counter signals end of frame, the block looks at the final byte count, the three error flags (CRC, code, alignment) and a flag marking a MAC control frame. It sorts the frame into length and error classes, builds a status footer from them, and applies three copy-enable policies plus a programmable maximum length.

A frame below the minimum length of 64 bytes is short. It is a fragment if it carries any error and undersized otherwise. A frame above the maximum length is long. It is jabber if it carries any error and oversized otherwise. Short frames, errored frames and control frames each have their own copy enable. A frame is kept only when every class it belongs to is allowed. The configuration (maximum length and the three enables) sits in a small register inside the block. It is loaded as a whole by a write strobe and resets to a 1518-byte maximum with all filtering active.

Top module: `rxcls`

## Requirements
- R1: After reset, `res_valid` and `res_keep` are 0, `res_footer` is 0, the maximum length is 1518 and all three copy enables are 0.
- R2: A result appears exactly one clock after the cycle in which `eof` is sampled high. `res_valid` is high for that single cycle. Strobes on consecutive cycles give results on consecutive cycles. When `res_valid` is low, `res_keep` and `res_footer` are 0.
- R3: A frame whose `byte_cnt` is below 64 is short. Footer bit 1 (fragment) is set if any error flag is set, and bit 0 (undersized) is set otherwise. A count of 64 is not short.
- R4: A frame whose `byte_cnt` exceeds the configured maximum is long. Footer bit 3 (jabber) is set if any error flag is set, and bit 2 (oversized) is set otherwise. A count equal to the maximum is not long. This holds at the largest maximum, 16383.
- R5: The error flags are reported in the footer: CRC in bit 4, code in bit 5, alignment in bit 6.
- R6: A MAC control frame sets footer bit 7.
- R7: A short frame is dropped (`res_keep`=0) unless copy-short is enabled.
- R8: A frame with any error flag is dropped unless copy-error is enabled.
- R9: A MAC control frame is dropped unless copy-control is enabled.
- R10: A frame is kept only if all its applicable classes are enabled. A frame in none of those classes is always kept, and this includes an error-free long frame.
- R11: `cfg_wr` loads the maximum length and the three enables together. A frame whose `eof` arrives in the same cycle as the write is judged with the previous configuration, and later frames use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the configuration register |
| cfg_max_len_in | input | 14 | New maximum frame length |
| cfg_copy_short_in | input | 1 | New copy-short enable |
| cfg_copy_err_in | input | 1 | New copy-error enable |
| cfg_copy_ctrl_in | input | 1 | New copy-control enable |
| eof | input | 1 | End-of-frame strobe; qualifies the frame inputs |
| byte_cnt | input | 16 | Final byte count of the frame |
| crc_err | input | 1 | Frame has a CRC error |
| code_err | input | 1 | Frame has a symbol code error |
| align_err | input | 1 | Frame has an alignment error |
| is_ctrl | input | 1 | Frame is a MAC control frame |
| res_valid | output | 1 | Result valid pulse |
| res_keep | output | 1 | 1 = forward frame, 0 = drop |
| res_footer | output | 8 | Classification footer (bit map in R3–R6) |

## Verification
Every result is due one clock after the `eof` strobe is sampled, and each configuration write counts for the first strobe in the cycle after it. The bench model therefore updates its expectation at each rising edge from the inputs present at that edge, using the configuration that held before any write in that same edge. It then compares all three outputs at the following falling edge. Directed frames hit the length boundaries 63/64, max/max+1 at three maximum settings, each error flag, control frames, back-to-back strobes and a write coincident with a strobe.

// File: rtl/rxcls_pkg.sv
package rxcls_pkg;

  // error flag vector positions
  localparam int ERR_W     = 3;
  localparam int ERR_CRC   = 0;
  localparam int ERR_CODE  = 1;
  localparam int ERR_ALIGN = 2;

  // filter classes, one copy enable each
  localparam int CLS_W     = 3;
  localparam int CLS_SHORT = 0;
  localparam int CLS_ERR   = 1;
  localparam int CLS_CTRL  = 2;

  // footer, msb first: ctrl(7) err(6:4) jabber(3) oversized(2) fragment(1) undersized(0)
  typedef struct packed {
    logic             ctrl;
    logic [ERR_W-1:0] err;
    logic             jabber;
    logic             oversized;
    logic             fragment;
    logic             undersized;
  } footer_t;

  localparam int FOOTER_W = $bits(footer_t);

endpackage

// File: rtl/rxcls_cfg.sv
module rxcls_cfg #(
  parameter int LEN_W   = 14,
  parameter int RST_MAX = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LEN_W-1:0] max_len_in,
  input  logic             copy_short_in,
  input  logic             copy_err_in,
  input  logic             copy_ctrl_in,
  output logic [LEN_W-1:0] max_len_q,
  output logic             copy_short_q,
  output logic             copy_err_q,
  output logic             copy_ctrl_q
);

  logic [LEN_W-1:0] max_len_d;
  logic             copy_short_d;
  logic             copy_err_d;
  logic             copy_ctrl_d;

  always_comb begin
    max_len_d    = max_len_q;
    copy_short_d = copy_short_q;
    copy_err_d   = copy_err_q;
    copy_ctrl_d  = copy_ctrl_q;
    if (wr) begin
      max_len_d    = max_len_in;
      copy_short_d = copy_short_in;
      copy_err_d   = copy_err_in;
      copy_ctrl_d  = copy_ctrl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_len_q    <= LEN_W'(RST_MAX);
      copy_short_q <= 1'b0;
      copy_err_q   <= 1'b0;
      copy_ctrl_q  <= 1'b0;
    end else begin
      max_len_q    <= max_len_d;
      copy_short_q <= copy_short_d;
      copy_err_q   <= copy_err_d;
      copy_ctrl_q  <= copy_ctrl_d;
    end
  end

endmodule

// File: rtl/rxcls_classify.sv
module rxcls_classify
  import rxcls_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64
) (
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [LEN_W-1:0] max_len,
  input  logic [ERR_W-1:0] err,
  input  logic             is_ctrl,
  output footer_t          footer
);

  logic is_short;
  logic is_long;
  logic any_err;

  always_comb begin
    is_short = byte_cnt < CNT_W'(MIN_LEN);
    is_long  = byte_cnt > CNT_W'(max_len);
    any_err  = |err;

    footer            = '0;
    footer.ctrl       = is_ctrl;
    footer.err        = err;
    footer.undersized = is_short && !any_err;
    footer.fragment   = is_short &&  any_err;
    footer.oversized  = is_long  && !any_err;
    footer.jabber     = is_long  &&  any_err;
  end

endmodule

// File: rtl/rxcls_policy.sv
module rxcls_policy
  import rxcls_pkg::*;
(
  input  footer_t          footer,
  input  logic [CLS_W-1:0] copy_en,
  output logic             keep
);

  logic [CLS_W-1:0] member;
  logic [CLS_W-1:0] allowed;

  always_comb begin
    member            = '0;
    member[CLS_SHORT] = footer.undersized | footer.fragment;
    member[CLS_ERR]   = |footer.err;
    member[CLS_CTRL]  = footer.ctrl;
  end

  for (genvar i = 0; i < CLS_W; i++) begin : g_cls
    assign allowed[i] = !member[i] || copy_en[i];
  end

  assign keep = &allowed;

endmodule

// File: rtl/rxcls.sv
module rxcls
  import rxcls_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int RST_MAX = 1518
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [LEN_W-1:0]    cfg_max_len_in,
  input  logic                cfg_copy_short_in,
  input  logic                cfg_copy_err_in,
  input  logic                cfg_copy_ctrl_in,
  input  logic                eof,
  input  logic [CNT_W-1:0]    byte_cnt,
  input  logic                crc_err,
  input  logic                code_err,
  input  logic                align_err,
  input  logic                is_ctrl,
  output logic                res_valid,
  output logic                res_keep,
  output logic [FOOTER_W-1:0] res_footer
);

  logic [LEN_W-1:0] cfg_max_len;
  logic             cfg_copy_short;
  logic             cfg_copy_err;
  logic             cfg_copy_ctrl;

  logic [ERR_W-1:0] err_vec;
  logic [CLS_W-1:0] copy_en;
  footer_t          cls_footer;
  logic             cls_keep;

  logic                valid_d;
  logic                keep_d;
  logic [FOOTER_W-1:0] footer_d;

  rxcls_cfg #(.LEN_W(LEN_W), .RST_MAX(RST_MAX)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr            (cfg_wr),
    .max_len_in    (cfg_max_len_in),
    .copy_short_in (cfg_copy_short_in),
    .copy_err_in   (cfg_copy_err_in),
    .copy_ctrl_in  (cfg_copy_ctrl_in),
    .max_len_q     (cfg_max_len),
    .copy_short_q  (cfg_copy_short),
    .copy_err_q    (cfg_copy_err),
    .copy_ctrl_q   (cfg_copy_ctrl)
  );

  always_comb begin
    err_vec            = '0;
    err_vec[ERR_CRC]   = crc_err;
    err_vec[ERR_CODE]  = code_err;
    err_vec[ERR_ALIGN] = align_err;
    copy_en            = '0;
    copy_en[CLS_SHORT] = cfg_copy_short;
    copy_en[CLS_ERR]   = cfg_copy_err;
    copy_en[CLS_CTRL]  = cfg_copy_ctrl;
  end

  rxcls_classify #(.CNT_W(CNT_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_classify (
    .byte_cnt (byte_cnt),
    .max_len  (cfg_max_len),
    .err      (err_vec),
    .is_ctrl  (is_ctrl),
    .footer   (cls_footer)
  );

  rxcls_policy u_policy (
    .footer  (cls_footer),
    .copy_en (copy_en),
    .keep    (cls_keep)
  );

  // result stage: outputs are zero outside the valid pulse
  always_comb begin
    valid_d  = eof;
    keep_d   = 1'b0;
    footer_d = '0;
    if (eof) begin
      keep_d   = cls_keep;
      footer_d = cls_footer;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_keep   <= 1'b0;
      res_footer <= '0;
    end else begin
      res_valid  <= valid_d;
      res_keep   <= keep_d;
      res_footer <= footer_d;
    end
  end

endmodule

// File: rtl/rxcls_chk.sv
module rxcls_chk #(
  parameter int FW = 8,
  parameter int LW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eof,
  input logic          cfg_wr,
  input logic          res_valid,
  input logic          res_keep,
  input logic [FW-1:0] res_footer,
  input logic [LW-1:0] max_len,
  input logic          cs,
  input logic          ce,
  input logic          cc
);

  p_valid_follows_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> res_valid);

  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |=> !res_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_keep && res_footer == '0));

  p_short_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_footer[1:0]));

  p_frag_has_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_footer[1] |-> (res_footer[6:4] != 3'b000));

  p_long_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_footer[3:2]));

  p_short_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eof && !cs |=> !(res_footer[1:0] != 2'b00 && res_keep));

  p_err_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eof && !ce |=> !(res_footer[6:4] != 3'b000 && res_keep));

  p_ctrl_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eof && !cc |=> !(res_footer[7] && res_keep));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(max_len) && $stable(cs) && $stable(ce) && $stable(cc)));

endmodule

bind rxcls rxcls_chk #(.FW(rxcls_pkg::FOOTER_W), .LW(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eof        (eof),
  .cfg_wr     (cfg_wr),
  .res_valid  (res_valid),
  .res_keep   (res_keep),
  .res_footer (res_footer),
  .max_len    (cfg_max_len),
  .cs         (cfg_copy_short),
  .ce         (cfg_copy_err),
  .cc         (cfg_copy_ctrl)
);

// File: tb/rxcls_test.sv
`timescale 1ns/1ps
module rxcls_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [13:0] cfg_max_len_in;
  logic        cfg_copy_short_in, cfg_copy_err_in, cfg_copy_ctrl_in;
  logic        eof;
  logic [15:0] byte_cnt;
  logic        crc_err, code_err, align_err, is_ctrl;
  logic        res_valid, res_keep;
  logic [7:0]  res_footer;

  int tests  = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  string cur_tag = "R1";
  string exp_tag = "R1";

  // behavioural model state
  int m_max   = 1518;
  bit m_cs    = 0;
  bit m_ce    = 0;
  bit m_cc    = 0;
  bit e_valid = 0;
  bit e_keep  = 0;
  int e_foot  = 0;

  rxcls uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_max_len_in(cfg_max_len_in),
    .cfg_copy_short_in(cfg_copy_short_in), .cfg_copy_err_in(cfg_copy_err_in),
    .cfg_copy_ctrl_in(cfg_copy_ctrl_in), .eof(eof), .byte_cnt(byte_cnt),
    .crc_err(crc_err), .code_err(code_err), .align_err(align_err), .is_ctrl(is_ctrl),
    .res_valid(res_valid), .res_keep(res_keep), .res_footer(res_footer)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_max = 1518; m_cs = 0; m_ce = 0; m_cc = 0;
      e_valid = 0; e_keep = 0; e_foot = 0;
      exp_tag = cur_tag;
    end else begin
      int  n;
      bit  errs, shrt, lng, ok;
      n    = int'(byte_cnt);
      errs = crc_err || code_err || align_err;
      shrt = n < 64;
      lng  = n > m_max;
      e_valid = eof;
      e_keep  = 0;
      e_foot  = 0;
      if (eof) begin
        if (shrt && !errs) e_foot += 1;
        if (shrt &&  errs) e_foot += 2;
        if (lng  && !errs) e_foot += 4;
        if (lng  &&  errs) e_foot += 8;
        if (crc_err)   e_foot += 16;
        if (code_err)  e_foot += 32;
        if (align_err) e_foot += 64;
        if (is_ctrl)   e_foot += 128;
        ok = 1;
        if (shrt && !m_cs) ok = 0;
        if (errs && !m_ce) ok = 0;
        if (is_ctrl && !m_cc) ok = 0;
        e_keep = ok;
      end
      exp_tag = cur_tag;
      if (cfg_wr) begin
        m_max = int'(cfg_max_len_in);
        m_cs = cfg_copy_short_in; m_ce = cfg_copy_err_in; m_cc = cfg_copy_ctrl_in;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      tests++;
      if (res_valid !== e_valid || res_keep !== e_keep || int'(res_footer) != e_foot) begin
        fails++;
        $display("FAIL %s: valid/keep/footer actual %0b/%0b/%02h expected %0b/%0b/%02h",
                 exp_tag, res_valid, res_keep, res_footer, e_valid, e_keep, e_foot[7:0]);
      end
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic frame(input int n, input bit c, input bit k, input bit a,
                       input bit ct, input string tag);
    @(negedge clk);
    cur_tag = tag;
    eof = 1; byte_cnt = 16'(n);
    crc_err = c; code_err = k; align_err = a; is_ctrl = ct;
    @(negedge clk);
    eof = 0; crc_err = 0; code_err = 0; align_err = 0; is_ctrl = 0;
  endtask

  task automatic setcfg(input int mx, input bit s, input bit e, input bit ct);
    @(negedge clk);
    cur_tag = "R11";
    cfg_wr = 1; cfg_max_len_in = 14'(mx);
    cfg_copy_short_in = s; cfg_copy_err_in = e; cfg_copy_ctrl_in = ct;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_max_len_in = 0;
    cfg_copy_short_in = 0; cfg_copy_err_in = 0; cfg_copy_ctrl_in = 0;
    eof = 0; byte_cnt = 0; crc_err = 0; code_err = 0; align_err = 0; is_ctrl = 0;
    repeat (3) @(negedge clk);
    // R1: reset state checked every cycle above while rst_n is low
    rst_n = 1;
    repeat (2) @(negedge clk);

    frame(100, 0, 0, 0, 0, "R10");   // plain frame kept
    frame(1518, 0, 0, 0, 0, "R1");   // default max: not long
    frame(1519, 0, 0, 0, 0, "R4");   // oversized, still kept (R10)
    frame(63, 0, 0, 0, 0, "R3");     // undersized, dropped (R7)
    frame(64, 0, 0, 0, 0, "R3");     // boundary, not short
    frame(40, 1, 0, 0, 0, "R7");     // fragment dropped
    frame(200, 0, 1, 0, 0, "R8");    // code error dropped
    frame(200, 0, 0, 1, 0, "R5");    // align error
    frame(2000, 1, 0, 0, 0, "R4");   // jabber dropped
    frame(64, 0, 0, 0, 1, "R9");     // control dropped

    // R2: back-to-back strobes
    @(negedge clk);
    cur_tag = "R2";
    eof = 1; byte_cnt = 16'd80;
    @(negedge clk);
    byte_cnt = 16'd30; crc_err = 1;
    @(negedge clk);
    eof = 0; crc_err = 0;
    repeat (2) @(negedge clk);

    setcfg(1518, 1, 0, 0);
    frame(63, 0, 0, 0, 0, "R7");     // kept undersized
    frame(40, 1, 0, 0, 0, "R10");    // short+err still dropped
    setcfg(1518, 1, 1, 0);
    frame(40, 1, 0, 0, 0, "R10");    // fragment kept
    frame(200, 1, 1, 1, 0, "R5");    // all error bits kept (R8)
    frame(3000, 0, 0, 1, 0, "R4");   // jabber kept
    frame(64, 0, 0, 0, 1, "R9");     // control still dropped
    setcfg(1518, 0, 0, 1);
    frame(64, 0, 0, 0, 1, "R6");     // control kept, bit 7
    frame(20, 0, 0, 0, 1, "R10");    // control+short dropped

    setcfg(100, 0, 0, 0);
    frame(100, 0, 0, 0, 0, "R4");
    frame(101, 0, 0, 0, 0, "R4");
    setcfg(16383, 0, 0, 0);
    frame(16383, 0, 0, 0, 0, "R4");
    frame(16384, 0, 0, 0, 0, "R4");

    // R11: write and strobe in the same cycle use the old config
    @(negedge clk);
    cur_tag = "R11";
    cfg_wr = 1; cfg_max_len_in = 14'd500;
    cfg_copy_short_in = 1; cfg_copy_err_in = 1; cfg_copy_ctrl_in = 1;
    eof = 1; byte_cnt = 16'd50; crc_err = 1; is_ctrl = 1;
    @(negedge clk);
    cfg_wr = 0;
    byte_cnt = 16'd50;               // same frame again, new config
    @(negedge clk);
    eof = 0; crc_err = 0; is_ctrl = 0;
    frame(501, 0, 0, 0, 0, "R11");
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule